// File: doc/BRIEF.md
# Register-Controlled Memory Chip-Select Decoder

This block turns a 24-bit CPU address into exactly one chip-select for a small computer, or into a "no select" indication. There are eleven possible targets: an internal 512-byte RAM, board SRAM, expansion RAM, on-board flash, cartridge ROM, expansion ROM, internal mask ROM, a video I/O window, internal peripherals, a clock-port window and a user expansion window. The address space is cut into twelve regions. The target of most regions is chosen by bits in three byte-wide configuration registers. The CPU writes these registers over the same bus.

The selects are combinational. They depend on the address, the write strobe, the active-low cartridge-present input and the registered configuration bits. A configuration write is captured on the clock edge that ends the bus cycle. Its effect shows from the following bus cycle onwards. When no device is chosen, `no_sel_o` rises so that external expansion hardware can claim the access.

Top module: `memsel_decoder`

Each select line has a fixed bit position in `sel_o`:

| Bit | Target |
|-----|--------|
| 0 | internal RAM |
| 1 | board SRAM |
| 2 | expansion RAM |
| 3 | flash |
| 4 | cartridge ROM |
| 5 | expansion ROM |
| 6 | mask ROM |
| 7 | video |
| 8 | peripherals |
| 9 | clock port |
| 10 | expansion window |

The three configuration registers are:

| Register | Address |
|----------|---------|
| chip-map | 0x00DF27 |
| boot-control | 0x00DF40 |
| system | 0x00DF41 |

The default region bounds, inclusive, are:

| Region | Low | High |
|--------|-----|------|
| 0 | 0x000000 | 0x0001FF |
| 1 | 0x000200 | 0x007FFF |
| 2 | 0x008000 | 0x00DEFF |
| 3 | 0x00DF00 | 0x00DF1F |
| 4 | 0x00DF20 | 0x00DF7F |
| 5 | 0x00DF80 | 0x00DFFF |
| 6 | 0x00E000 | 0x00FFFF |
| 7 | 0x010000 | 0x1FFFFF |
| 8 | 0x200000 | 0x3FFFFF |
| 9 | 0x400000 | 0xBFFFFF |
| 10 | 0xC08000 | 0xC0DEFF |
| 11 | 0xC80000 | 0xFFFFFF |

Addresses between these regions belong to no region.

## Requirements
- R1: Reset clears all three configuration registers to 0x00. After reset, region 6 selects mask ROM (bit 6), region 0 selects internal RAM (bit 0), and every register-gated region selects nothing.
- R2: A write (`cpu_we`=1) to 0x00DF27, 0x00DF40 or 0x00DF41 loads `cpu_wdata` into that register. The new value steers selection from the next clock cycle. A write to any other address leaves all three registers unchanged.
- R3: Region 0 selects board SRAM (bit 1) when bit 2 of the system register is set. Otherwise it selects internal RAM (bit 0).
- R4: Region 1 selects board SRAM only when chip-map bit 5 is set and chip-map bit 3 is clear. Otherwise it selects nothing.
- R5: With chip-map bit 4 set, a read in region 2 selects flash (bit 3) while `cart_n` is high and cartridge ROM (bit 4) while `cart_n` is low. With chip-map bit 4 clear, region 2 selects nothing.
- R6: With boot-control bit 7 clear, region 6 selects mask ROM. With it set, a read in region 6 selects flash if chip-map bit 4 is set, else SRAM if chip-map bit 5 is set, else nothing.
- R7: Region 7 selects board SRAM and region 8 selects expansion RAM (bit 2), both only while chip-map bit 5 is set. Region 9 selects the expansion window (bit 10) only while chip-map bit 6 is set.
- R8: Region 10 selects flash and region 11 selects expansion ROM (bit 5), both only while chip-map bit 7 is set.
- R9: In region 2, and in region 6 with boot-control bit 7 set, a write with chip-map bits 4 and 5 both set selects board SRAM. With bit 4 set and bit 5 clear, a write selects the same ROM a read would.
- R10: Regions 3, 4 and 5 always select video (bit 7), peripherals (bit 8) and clock port (bit 9) respectively, whatever the registers hold.
- R11: `no_sel_o` is high exactly when `sel_o` is all zero. This happens when the region selects nothing or the address lies outside every region.
- R12: At most one bit of `sel_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 24 | CPU byte address |
| cpu_we | input | 1 | 1 = write cycle, 0 = read cycle |
| cpu_wdata | input | 8 | Write data, used for configuration writes |
| cart_n | input | 1 | Cartridge-present, active low |
| sel_o | output | 11 | One-hot chip-selects, bit positions as listed above |
| no_sel_o | output | 1 | High when no target is selected |

## Verification
Selects follow the address, `cpu_we` and `cart_n` in the same cycle, so the bench drives inputs on the falling edge and compares `sel_o` and `no_sel_o` one time unit later. A configuration write only becomes visible after the next rising edge. The bench therefore updates its model registers after that cycle's comparison, so the write cycle itself is still judged with the old values. Directed sequences check the read/write split, the cartridge input, a write to a neighbouring non-register address and gaps between regions. Random accesses mixed with random register writes cover the rest.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

    typedef enum logic [3:0] {
        TGT_IRAM   = 4'd0,
        TGT_SRAM   = 4'd1,
        TGT_XRAM   = 4'd2,
        TGT_FLASH  = 4'd3,
        TGT_CROM   = 4'd4,
        TGT_XROM   = 4'd5,
        TGT_MROM   = 4'd6,
        TGT_VIDEO  = 4'd7,
        TGT_PERIPH = 4'd8,
        TGT_CLKP   = 4'd9,
        TGT_XWIN   = 4'd10,
        TGT_NONE   = 4'd11
    } tgt_e;

    localparam int NUM_TGT    = 11;
    localparam int NUM_REGION = 12;
    localparam int RIDX_W     = $clog2(NUM_REGION);

    // region numbers
    localparam int RG_LOW      = 0;
    localparam int RG_LOWRAM   = 1;
    localparam int RG_ROMWIN   = 2;
    localparam int RG_VIDEO    = 3;
    localparam int RG_PERIPH   = 4;
    localparam int RG_CLKP     = 5;
    localparam int RG_BOOT     = 6;
    localparam int RG_SRAM     = 7;
    localparam int RG_XRAM     = 8;
    localparam int RG_XWIN     = 9;
    localparam int RG_HIFLASH  = 10;
    localparam int RG_HIXROM   = 11;

    // configuration bit positions
    localparam int MAP_LORAM_OFF = 3;
    localparam int MAP_ROM_EN    = 4;
    localparam int MAP_RAM_EN    = 5;
    localparam int MAP_XWIN_EN   = 6;
    localparam int MAP_HIROM_EN  = 7;
    localparam int BOOT_EXT      = 7;
    localparam int SYS_SRAM_LOW  = 2;

endpackage

// File: rtl/memsel_cfg_regs.sv
module memsel_cfg_regs #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] MAP_ADDR  = 24'h00DF27,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = 24'h00DF40,
    parameter logic [ADDR_W-1:0] SYS_ADDR  = 24'h00DF41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] map_q,
    output logic [DATA_W-1:0] boot_q,
    output logic [DATA_W-1:0] sys_q
);

    logic hit_map;
    logic hit_boot;
    logic hit_sys;

    always_comb begin
        hit_map  = we && (addr == MAP_ADDR);
        hit_boot = we && (addr == BOOT_ADDR);
        hit_sys  = we && (addr == SYS_ADDR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q  <= '0;
            boot_q <= '0;
            sys_q  <= '0;
        end else begin
            if (hit_map)  map_q  <= wdata;
            if (hit_boot) boot_q <= wdata;
            if (hit_sys)  sys_q  <= wdata;
        end
    end

    // R2
    map_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == MAP_ADDR) |=> (map_q == $past(wdata)));

    // R2
    boot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == BOOT_ADDR) |=> (boot_q == $past(wdata)));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (addr == MAP_ADDR || addr == BOOT_ADDR || addr == SYS_ADDR))
        |=> ($stable(map_q) && $stable(boot_q) && $stable(sys_q)));

endmodule

// File: rtl/memsel_region_match.sv
module memsel_region_match #(
    parameter int ADDR_W = 24,
    parameter int NREG   = 12,
    parameter logic [NREG*ADDR_W-1:0] LO = '0,
    parameter logic [NREG*ADDR_W-1:0] HI = '0,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  region_idx,
    output logic              region_hit
);

    logic [NREG-1:0] hits;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_cmp
            localparam logic [ADDR_W-1:0] B_LO = LO[g*ADDR_W +: ADDR_W];
            localparam logic [ADDR_W-1:0] B_HI = HI[g*ADDR_W +: ADDR_W];
            assign hits[g] = (addr >= B_LO) && (addr <= B_HI);
        end
    endgenerate

    always_comb begin
        region_idx = '0;
        region_hit = 1'b0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hits[i]) begin
                region_idx = IDX_W'(i);
                region_hit = 1'b1;
            end
        end
    end

    // R12
    region_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hits));

endmodule

// File: rtl/memsel_target_map.sv
module memsel_target_map
    import memsel_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] region_idx,
    input  logic              region_hit,
    input  logic              we,
    input  logic              cart_n,
    input  logic [DATA_W-1:0] map_q,
    input  logic [DATA_W-1:0] boot_q,
    input  logic [DATA_W-1:0] sys_q,
    output tgt_e              tgt
);

    logic rom_en;
    logic ram_en;
    logic split_wr;
    tgt_e low_rom;

    always_comb begin
        rom_en   = map_q[MAP_ROM_EN];
        ram_en   = map_q[MAP_RAM_EN];
        split_wr = we && rom_en && ram_en;
        low_rom  = cart_n ? TGT_FLASH : TGT_CROM;
    end

    always_comb begin
        tgt = TGT_NONE;
        if (region_hit) begin
            case (int'(region_idx))
                RG_LOW:     tgt = sys_q[SYS_SRAM_LOW] ? TGT_SRAM : TGT_IRAM;
                RG_LOWRAM:  tgt = (ram_en && !map_q[MAP_LORAM_OFF]) ? TGT_SRAM : TGT_NONE;
                RG_ROMWIN: begin
                    if (!rom_en)       tgt = TGT_NONE;
                    else if (split_wr) tgt = TGT_SRAM;
                    else               tgt = low_rom;
                end
                RG_VIDEO:   tgt = TGT_VIDEO;
                RG_PERIPH:  tgt = TGT_PERIPH;
                RG_CLKP:    tgt = TGT_CLKP;
                RG_BOOT: begin
                    if (!boot_q[BOOT_EXT]) tgt = TGT_MROM;
                    else if (rom_en)       tgt = split_wr ? TGT_SRAM : TGT_FLASH;
                    else if (ram_en)       tgt = TGT_SRAM;
                    else                   tgt = TGT_NONE;
                end
                RG_SRAM:    tgt = ram_en ? TGT_SRAM : TGT_NONE;
                RG_XRAM:    tgt = ram_en ? TGT_XRAM : TGT_NONE;
                RG_XWIN:    tgt = map_q[MAP_XWIN_EN] ? TGT_XWIN : TGT_NONE;
                RG_HIFLASH: tgt = map_q[MAP_HIROM_EN] ? TGT_FLASH : TGT_NONE;
                RG_HIXROM:  tgt = map_q[MAP_HIROM_EN] ? TGT_XROM : TGT_NONE;
                default:    tgt = TGT_NONE;
            endcase
        end
    end

    // R10
    fixed_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region_hit && int'(region_idx) == RG_PERIPH) |-> (tgt == TGT_PERIPH));

    // R6
    boot_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region_hit && int'(region_idx) == RG_BOOT && !boot_q[BOOT_EXT]) |-> (tgt == TGT_MROM));

    // R8
    hirom_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region_hit && int'(region_idx) >= RG_HIFLASH && !map_q[MAP_HIROM_EN]) |-> (tgt == TGT_NONE));

    // R9
    split_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region_hit && int'(region_idx) == RG_ROMWIN && we && map_q[MAP_ROM_EN] && map_q[MAP_RAM_EN])
        |-> (tgt == TGT_SRAM));

endmodule

// File: rtl/memsel_sel_encode.sv
module memsel_sel_encode
    import memsel_pkg::*;
(
    input  tgt_e               tgt,
    output logic [NUM_TGT-1:0] sel,
    output logic               none
);

    generate
        for (genvar g = 0; g < NUM_TGT; g++) begin : g_line
            assign sel[g] = (tgt == tgt_e'(g));
        end
    endgenerate

    assign none = (tgt == TGT_NONE);

endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
    import memsel_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] MAP_ADDR  = 24'h00DF27,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = 24'h00DF40,
    parameter logic [ADDR_W-1:0] SYS_ADDR  = 24'h00DF41,
    parameter logic [NUM_REGION*ADDR_W-1:0] REGION_LO = {
        24'hC80000, 24'hC08000, 24'h400000, 24'h200000,
        24'h010000, 24'h00E000, 24'h00DF80, 24'h00DF20,
        24'h00DF00, 24'h008000, 24'h000200, 24'h000000},
    parameter logic [NUM_REGION*ADDR_W-1:0] REGION_HI = {
        24'hFFFFFF, 24'hC0DEFF, 24'hBFFFFF, 24'h3FFFFF,
        24'h1FFFFF, 24'h00FFFF, 24'h00DFFF, 24'h00DF7F,
        24'h00DF1F, 24'h00DEFF, 24'h007FFF, 24'h0001FF}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_we,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               cart_n,
    output logic [NUM_TGT-1:0] sel_o,
    output logic               no_sel_o
);

    logic [DATA_W-1:0] map_q;
    logic [DATA_W-1:0] boot_q;
    logic [DATA_W-1:0] sys_q;
    logic [RIDX_W-1:0] region_idx;
    logic              region_hit;
    tgt_e              tgt;

    memsel_cfg_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MAP_ADDR  (MAP_ADDR),
        .BOOT_ADDR (BOOT_ADDR),
        .SYS_ADDR  (SYS_ADDR)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (cpu_addr),
        .we     (cpu_we),
        .wdata  (cpu_wdata),
        .map_q  (map_q),
        .boot_q (boot_q),
        .sys_q  (sys_q)
    );

    memsel_region_match #(
        .ADDR_W (ADDR_W),
        .NREG   (NUM_REGION),
        .LO     (REGION_LO),
        .HI     (REGION_HI)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (cpu_addr),
        .region_idx (region_idx),
        .region_hit (region_hit)
    );

    memsel_target_map #(
        .DATA_W (DATA_W)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .region_idx (region_idx),
        .region_hit (region_hit),
        .we         (cpu_we),
        .cart_n     (cart_n),
        .map_q      (map_q),
        .boot_q     (boot_q),
        .sys_q      (sys_q),
        .tgt        (tgt)
    );

    memsel_sel_encode u_enc (
        .tgt  (tgt),
        .sel  (sel_o),
        .none (no_sel_o)
    );

    // R12
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    // R11
    no_sel_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_sel_o == (sel_o == '0));

    // R11
    gap_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !region_hit |-> no_sel_o);

endmodule

// File: tb/test_memsel_decoder.sv
module test_memsel_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NTGT = 11;
    localparam int TNONE = 11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [23:0]     cpu_addr = '0;
    logic            cpu_we = 1'b0;
    logic [7:0]      cpu_wdata = '0;
    logic            cart_n = 1'b1;
    logic [NTGT-1:0] sel_o;
    logic            no_sel_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_map = '0;
    logic [7:0] m_boot = '0;
    logic [7:0] m_sys = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memsel_decoder i_memsel_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_we    (cpu_we),
        .cpu_wdata (cpu_wdata),
        .cart_n    (cart_n),
        .sel_o     (sel_o),
        .no_sel_o  (no_sel_o)
    );

    function automatic logic [23:0] rlo(int r);
        case (r)
            0: return 24'h000000;  1: return 24'h000200;  2: return 24'h008000;
            3: return 24'h00DF00;  4: return 24'h00DF20;  5: return 24'h00DF80;
            6: return 24'h00E000;  7: return 24'h010000;  8: return 24'h200000;
            9: return 24'h400000; 10: return 24'hC08000;
            default: return 24'hC80000;
        endcase
    endfunction

    function automatic logic [23:0] rhi(int r);
        case (r)
            0: return 24'h0001FF;  1: return 24'h007FFF;  2: return 24'h00DEFF;
            3: return 24'h00DF1F;  4: return 24'h00DF7F;  5: return 24'h00DFFF;
            6: return 24'h00FFFF;  7: return 24'h1FFFFF;  8: return 24'h3FFFFF;
            9: return 24'hBFFFFF; 10: return 24'hC0DEFF;
            default: return 24'hFFFFFF;
        endcase
    endfunction

    function automatic int region_of(logic [23:0] a);
        for (int r = 0; r < 12; r++)
            if (a >= rlo(r) && a <= rhi(r)) return r;
        return 12;
    endfunction

    function automatic int exp_tgt(logic [23:0] a, logic we, logic cn);
        logic rom, ram;
        rom = m_map[4];
        ram = m_map[5];
        case (region_of(a))
            0: return m_sys[2] ? 1 : 0;
            1: return (ram && !m_map[3]) ? 1 : TNONE;
            2: return !rom ? TNONE : (we && ram) ? 1 : (cn ? 3 : 4);
            3: return 7;
            4: return 8;
            5: return 9;
            6: begin
                if (!m_boot[7]) return 6;
                if (rom) return (we && ram) ? 1 : 3;
                return ram ? 1 : TNONE;
            end
            7: return ram ? 1 : TNONE;
            8: return ram ? 2 : TNONE;
            9: return m_map[6] ? 10 : TNONE;
            10: return m_map[7] ? 3 : TNONE;
            11: return m_map[7] ? 5 : TNONE;
            default: return TNONE;
        endcase
    endfunction

    function automatic string req_of(logic [23:0] a, logic we);
        case (region_of(a))
            0: return "R3";
            1: return "R4";
            2: return (we && m_map[4]) ? "R9" : "R5";
            3, 4, 5: return "R10";
            6: return (we && m_boot[7] && m_map[4]) ? "R9" : "R6";
            7, 8, 9: return "R7";
            10, 11: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check_now(string tag);
        int t;
        logic [NTGT-1:0] es;
        t = exp_tgt(cpu_addr, cpu_we, cart_n);
        es = (t == TNONE) ? '0 : NTGT'(1) << t;
        checks++;
        if (sel_o !== es || no_sel_o !== (t == TNONE)) begin
            failures++;
            $display("FAIL %s addr=%06h we=%0b: sel=%03h no_sel=%0b expected sel=%03h no_sel=%0b",
                     tag, cpu_addr, cpu_we, sel_o, no_sel_o, es, (t == TNONE));
        end
        // R12 one-hot at the port
        checks++;
        if ($countones(sel_o) > 1) begin
            failures++;
            $display("FAIL R12 sel=%03h expected at most one bit", sel_o);
        end
    endtask

    task automatic access(logic [23:0] a, logic we, logic [7:0] d, logic cn, string tag);
        @(negedge clk);
        cpu_addr = a;
        cpu_we = we;
        cpu_wdata = d;
        cart_n = cn;
        #1;
        check_now(tag);
        if (we) begin
            if (a == 24'h00DF27) m_map = d;
            if (a == 24'h00DF40) m_boot = d;
            if (a == 24'h00DF41) m_sys = d;
        end
    endtask

    task automatic auto_access(logic [23:0] a, logic we, logic cn);
        access(a, we, 8'h00, cn, req_of(a, we));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        access(24'h00F000, 1'b0, 8'h00, 1'b1, "R1");
        access(24'h000010, 1'b0, 8'h00, 1'b1, "R1");
        access(24'h001000, 1'b0, 8'h00, 1'b1, "R1");
        access(24'h050000, 1'b0, 8'h00, 1'b1, "R1");
        access(24'hC09000, 1'b0, 8'h00, 1'b1, "R1");
        access(24'h009000, 1'b0, 8'h00, 1'b1, "R1");

        // R2 write to neighbouring non-register address ignored
        access(24'h00DF28, 1'b1, 8'hFF, 1'b1, "R2");
        access(24'hC09000, 1'b0, 8'h00, 1'b1, "R2");
        access(24'h00DF42, 1'b1, 8'hFF, 1'b1, "R2");
        access(24'h00F000, 1'b0, 8'h00, 1'b1, "R2");

        // R2 write takes effect next cycle; R5 cartridge select
        access(24'h00DF27, 1'b1, 8'h10, 1'b1, "R2");
        access(24'h009000, 1'b0, 8'h00, 1'b1, "R5");
        access(24'h009000, 1'b0, 8'h00, 1'b0, "R5");
        // R9 write with ROM only still hits ROM
        access(24'h009000, 1'b1, 8'h00, 1'b1, "R9");

        // R9 split read / write
        access(24'h00DF27, 1'b1, 8'h30, 1'b1, "R2");
        access(24'h00DEFF, 1'b0, 8'h00, 1'b0, "R9");
        access(24'h00DEFF, 1'b1, 8'h00, 1'b0, "R9");
        access(24'h00DF40, 1'b1, 8'h80, 1'b1, "R2");
        access(24'h00E000, 1'b0, 8'h00, 1'b1, "R9");
        access(24'h00FFFF, 1'b1, 8'h00, 1'b1, "R9");

        // R3 system bit
        access(24'h00DF41, 1'b1, 8'h04, 1'b1, "R2");
        access(24'h0001FF, 1'b0, 8'h00, 1'b1, "R3");

        // R11 gaps
        access(24'hC00000, 1'b0, 8'h00, 1'b1, "R11");
        access(24'hC0DF00, 1'b0, 8'h00, 1'b1, "R11");
        access(24'hC7FFFF, 1'b1, 8'h00, 1'b1, "R11");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [23:0] a;
            if ($urandom % 8 == 0) begin
                int k;
                k = $urandom % 3;
                a = (k == 0) ? 24'h00DF27 : (k == 1) ? 24'h00DF40 : 24'h00DF41;
                access(a, 1'b1, 8'($urandom), 1'($urandom), "R2");
            end else begin
                r = $urandom % 13;
                if (r == 12)
                    a = 24'($urandom);
                else
                    a = rlo(r) + 24'($urandom % (32'(rhi(r) - rlo(r)) + 1));
                auto_access(a, 1'($urandom), 1'($urandom));
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule